// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block sits between a 32-bit register/memory bus and an embedded nonvolatile array of up to eight blocks. It holds the control fields for a program operation, collects data words into one page buffer per block, and gates the per-block high-voltage enables. Software follows a fixed flow. It clears the lock bit, loads the pulse-width and margin fields, and chooses the target blocks with an 8-bit mask. It then opens a session, writes the page data, and finally requests high voltage.

The first data write of a session fixes the page offset. Every later array access is steered to that page whatever address the bus presents. A read that names a different page is flagged as a margin read. All selected blocks share the one latched offset and receive high voltage together. An external engine reads the buffered words back through a side port while it programs. The pump, the pulse timing and the array itself are outside the block.

Top module: `flash_pgm_seq`

## Requirements
- R1: After a synchronous active-high reset, the control-1 register (bus register space, addr[3:2]=0) reads 0x1, which means lock=1 in bit 0, pulse width in [3:1] at 0 and margin bits [5:4] at 0. Control-2 (addr[3:2]=1) and status (addr[3:2]=2) read 0. `hvBlk` and `pageValid` are 0.
- R2: While the lock bit (control-1 bit 0) is 1, `hvBlk` is all zero, whatever the other fields hold. Clearing the lock bit again restores the enables of a request that is still pending.
- R3: While `pgmEn` is 0, `hvBlk` is all zero. While `blk0En` is 0, `hvBlk[0]` is 0 and the other blocks are not affected.
- R4: Control-2 holds the block mask in [7:0], the erase bit in 8, session enable in 9 and the high-voltage request in 10. An accepted request drives `hvBlk` equal to the mask when the lock bit is 0 and both enable inputs are 1.
- R5: The first array write after session enable latches the page offset from addr[13:6]. `pageOff` and `pageValid` (status bit 5) show it from the next cycle, and later writes to other offsets do not move it.
- R6: Address bits [5:2] pick the word inside the page buffer. When a word is written more than once, only the last value is kept. A word that was never written reads back through `pgmWordValid` as 0.
- R7: Address bits [16:14] name the target block. A write lands only if that block's mask bit is set. A write to an unselected block leaves every buffer word unwritten.
- R8: Once the page is latched, an array read drives `arrAddr` with the latched offset in place of the presented one. `marginRd` is 1 exactly when the presented offset differs from the latched one.
- R9: A high-voltage request is ignored and sets the error bit (status bit 4) in three cases: session enable is 0, no page is latched yet, or the same write clears session enable. Writing 1 to status bit 4 clears the error.
- R10: An accepted request stores, in status [3:0], the number of selected blocks whose buffers hold no written word.
- R11: Clearing session enable drops `hvBlk` right after the write. In the next cycle it clears `pageValid` and every written flag.
- R12: Array writes while session enable is 0 are ignored. No page latches and no word is marked written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busRegSel | input | 1 | 1 = register space, 0 = array space |
| busAddr | input | 17 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (registers or array) |
| pgmEn | input | 1 | Global program enable |
| blk0En | input | 1 | Block 0 program enable |
| arrRdEn | output | 1 | Array read strobe |
| arrAddr | output | 17 | Array address after page steering |
| arrRdData | input | 32 | Data returned by the array |
| marginRd | output | 1 | Off-page read flagged as margin read |
| pageValid | output | 1 | Page offset latched |
| pageOff | output | 8 | Latched page offset |
| pulseSel | output | 3 | Pulse-width field |
| marginCtl | output | 2 | Margin-control bits |
| hvBlk | output | 8 | Per-block high-voltage enables |
| pgmBlk | input | 3 | Buffer read-back block |
| pgmWord | input | 4 | Buffer read-back word |
| pgmData | output | 32 | Buffered word |
| pgmWordValid | output | 1 | Buffered word was written |

## Verification
The case that matters most is one control-2 write that raises the high-voltage request and drops session enable at the same edge. The accept path and the session-teardown path both act on that edge. The bench opens a session and latches a page so that the request would otherwise pass. It then issues that combined write and expects the request bit to stay clear, `hvBlk` to stay zero and the error bit to be set. A second race is checked the same way: the lock bit is set while a request is pending, and the enables must drop and later come back.

// File: rtl/fps_pkg.sv
package fps_pkg;
  // strobes the control half sends to the datapath half
  typedef struct packed {
    logic dataWr;   // array write accepted into the buffers
    logic sessClr;  // session closed: drop page and written flags
  } fps_strb_t;

  localparam logic [1:0] REG_CTL1 = 2'd0;
  localparam logic [1:0] REG_CTL2 = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int DW      = 32,
  localparam int CW     = NUM_BLK + 3,
  localparam int CNTW   = $clog2(NUM_BLK + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWr,
  input  logic               busRegSel,
  input  logic [1:0]         regIdx,
  input  logic [CW-1:0]      ctlWdata,
  input  logic               pageValid,
  input  logic [NUM_BLK-1:0] blkEmpty,
  input  logic               pgmEn,
  input  logic               blk0En,
  output logic [DW-1:0]      regRdata,
  output logic               lockBit,
  output logic [2:0]         pulseSel,
  output logic [1:0]         marginCtl,
  output logic [NUM_BLK-1:0] blkMask,
  output logic               sessOn,
  output logic [NUM_BLK-1:0] hvBlk,
  output fps_strb_t          strb
);
  localparam int ERASE_B = NUM_BLK;
  localparam int SESS_B  = NUM_BLK + 1;
  localparam int HV_B    = NUM_BLK + 2;

  logic            eraseSel;
  logic            hvReq;
  logic            hvErr;
  logic [CNTW-1:0] emptyCnt;
  logic            regWr, wrCtl1, wrCtl2, wrStat;
  logic            hvAccept;
  logic [NUM_BLK-1:0] blk0Gate;

  assign regWr  = busSel && busWr && busRegSel;
  assign wrCtl1 = regWr && (regIdx == REG_CTL1);
  assign wrCtl2 = regWr && (regIdx == REG_CTL2);
  assign wrStat = regWr && (regIdx == REG_STAT);

  // request passes only with an open session that stays open and a latched page
  assign hvAccept = sessOn && ctlWdata[SESS_B] && pageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      lockBit   <= 1'b1;
      pulseSel  <= '0;
      marginCtl <= '0;
      blkMask   <= '0;
      eraseSel  <= 1'b0;
      sessOn    <= 1'b0;
      hvReq     <= 1'b0;
      hvErr     <= 1'b0;
      emptyCnt  <= '0;
    end else begin
      if (wrCtl1) begin
        lockBit   <= ctlWdata[0];
        pulseSel  <= ctlWdata[3:1];
        marginCtl <= ctlWdata[5:4];
      end
      if (wrCtl2) begin
        blkMask  <= ctlWdata[NUM_BLK-1:0];
        eraseSel <= ctlWdata[ERASE_B];
        sessOn   <= ctlWdata[SESS_B];
        if (ctlWdata[HV_B]) begin
          if (hvAccept) begin
            hvReq    <= 1'b1;
            emptyCnt <= CNTW'($countones(ctlWdata[NUM_BLK-1:0] & blkEmpty));
          end else begin
            hvReq <= 1'b0;
            hvErr <= 1'b1;
          end
        end else begin
          hvReq <= 1'b0;
        end
      end else if (!sessOn) begin
        hvReq <= 1'b0;
      end
      if (wrStat && ctlWdata[CNTW]) begin
        hvErr <= 1'b0;
      end
    end
  end

  assign blk0Gate = {{(NUM_BLK-1){1'b1}}, blk0En};
  assign hvBlk    = (hvReq && !lockBit && pgmEn) ? (blkMask & blk0Gate) : '0;

  always_comb begin
    case (regIdx)
      REG_CTL1: regRdata = DW'({marginCtl, pulseSel, lockBit});
      REG_CTL2: regRdata = DW'({hvReq, sessOn, eraseSel, blkMask});
      REG_STAT: regRdata = DW'({pageValid, hvErr, emptyCnt});
      default:  regRdata = '0;
    endcase
  end

  assign strb.dataWr  = busSel && busWr && !busRegSel && sessOn;
  assign strb.sessClr = !sessOn;
endmodule

// File: rtl/fps_dp.sv
module fps_dp
  import fps_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int WORDS   = 16,
  parameter int DW      = 32,
  parameter int OFFW    = 8,
  localparam int BLKB   = $clog2(NUM_BLK),
  localparam int WRDB   = $clog2(WORDS),
  localparam int AW     = 2 + WRDB + OFFW + BLKB
) (
  input  logic               clk,
  input  logic               rst,
  input  fps_strb_t          strb,
  input  logic [NUM_BLK-1:0] blkMask,
  input  logic               busSel,
  input  logic               busWr,
  input  logic               busRegSel,
  input  logic [AW-1:0]      busAddr,
  input  logic [DW-1:0]      busWdata,
  input  logic [BLKB-1:0]    pgmBlk,
  input  logic [WRDB-1:0]    pgmWord,
  output logic               pageValid,
  output logic [OFFW-1:0]    pageOff,
  output logic [NUM_BLK-1:0] blkEmpty,
  output logic               arrRdEn,
  output logic [AW-1:0]      arrAddr,
  output logic               marginRd,
  output logic [DW-1:0]      pgmData,
  output logic               pgmWordValid
);
  logic [WRDB-1:0] wordIdx;
  logic [OFFW-1:0] offIdx;
  logic [BLKB-1:0] blkIdx;

  assign wordIdx = busAddr[2 +: WRDB];
  assign offIdx  = busAddr[2 + WRDB +: OFFW];
  assign blkIdx  = busAddr[2 + WRDB + OFFW +: BLKB];

  logic [DW-1:0]                 bufMem [NUM_BLK][WORDS];
  logic [NUM_BLK-1:0][WORDS-1:0] bufFlag;

  // page offset is taken from the first write of a session only
  always_ff @(posedge clk) begin
    if (rst || strb.sessClr) begin
      pageValid <= 1'b0;
      pageOff   <= '0;
    end else if (strb.dataWr && !pageValid) begin
      pageValid <= 1'b1;
      pageOff   <= offIdx;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BLK; b++) begin
      if (strb.dataWr && blkMask[b] && (blkIdx == BLKB'(b))) begin
        bufMem[b][wordIdx] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.sessClr) begin
      bufFlag <= '0;
    end else begin
      for (int b = 0; b < NUM_BLK; b++) begin
        if (strb.dataWr && blkMask[b] && (blkIdx == BLKB'(b))) begin
          bufFlag[b][wordIdx] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_empty
    assign blkEmpty[g] = ~|bufFlag[g];
  end

  assign pgmData      = bufMem[pgmBlk][pgmWord];
  assign pgmWordValid = bufFlag[pgmBlk][pgmWord];

  // array reads are steered onto the latched page
  assign arrRdEn  = busSel && !busWr && !busRegSel;
  assign arrAddr  = pageValid ? {blkIdx, pageOff, wordIdx, 2'b00} : busAddr;
  assign marginRd = arrRdEn && pageValid && (offIdx != pageOff);
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import fps_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int WORDS   = 16,
  parameter int DW      = 32,
  parameter bit BIG_CFG = 1'b0,
  localparam int OFFW   = BIG_CFG ? 9 : 8,
  localparam int BLKB   = $clog2(NUM_BLK),
  localparam int WRDB   = $clog2(WORDS),
  localparam int AW     = 2 + WRDB + OFFW + BLKB,
  localparam int CW     = NUM_BLK + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busSel,
  input  logic               busWr,
  input  logic               busRegSel,
  input  logic [AW-1:0]      busAddr,
  input  logic [DW-1:0]      busWdata,
  output logic [DW-1:0]      busRdata,
  input  logic               pgmEn,
  input  logic               blk0En,
  output logic               arrRdEn,
  output logic [AW-1:0]      arrAddr,
  input  logic [DW-1:0]      arrRdData,
  output logic               marginRd,
  output logic               pageValid,
  output logic [OFFW-1:0]    pageOff,
  output logic [2:0]         pulseSel,
  output logic [1:0]         marginCtl,
  output logic [NUM_BLK-1:0] hvBlk,
  input  logic [BLKB-1:0]    pgmBlk,
  input  logic [WRDB-1:0]    pgmWord,
  output logic [DW-1:0]      pgmData,
  output logic               pgmWordValid
);
  fps_strb_t          strb;
  logic [DW-1:0]      regRdata;
  logic               lockBit;
  logic               sessOn;
  logic [NUM_BLK-1:0] blkMask;
  logic [NUM_BLK-1:0] blkEmpty;

  fps_ctrl #(.NUM_BLK(NUM_BLK), .DW(DW)) ctrl_i (
    .clk(clk), .rst(rst),
    .busSel(busSel), .busWr(busWr), .busRegSel(busRegSel),
    .regIdx(busAddr[3:2]), .ctlWdata(busWdata[CW-1:0]),
    .pageValid(pageValid), .blkEmpty(blkEmpty),
    .pgmEn(pgmEn), .blk0En(blk0En),
    .regRdata(regRdata), .lockBit(lockBit), .pulseSel(pulseSel),
    .marginCtl(marginCtl), .blkMask(blkMask), .sessOn(sessOn),
    .hvBlk(hvBlk), .strb(strb)
  );

  fps_dp #(.NUM_BLK(NUM_BLK), .WORDS(WORDS), .DW(DW), .OFFW(OFFW)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .blkMask(blkMask),
    .busSel(busSel), .busWr(busWr), .busRegSel(busRegSel),
    .busAddr(busAddr), .busWdata(busWdata),
    .pgmBlk(pgmBlk), .pgmWord(pgmWord),
    .pageValid(pageValid), .pageOff(pageOff), .blkEmpty(blkEmpty),
    .arrRdEn(arrRdEn), .arrAddr(arrAddr), .marginRd(marginRd),
    .pgmData(pgmData), .pgmWordValid(pgmWordValid)
  );

  assign busRdata = busRegSel ? regRdata : arrRdData;
endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int NUM_BLK = 8,
  parameter int OFFW    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               lockBit,
  input logic               sessOn,
  input logic               pgmEn,
  input logic               blk0En,
  input logic [NUM_BLK-1:0] hvBlk,
  input logic               pageValid,
  input logic [OFFW-1:0]    pageOff
);
  // R2
  no_hv_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    lockBit |-> (hvBlk == '0));
  // R3
  no_hv_without_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !pgmEn |-> (hvBlk == '0));
  // R3
  no_hv_blk0_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !blk0En |-> !hvBlk[0]);
  // R9
  hv_needs_page_chk: assert property (@(posedge clk) disable iff (rst)
    (hvBlk != '0) |-> (pageValid && sessOn));
  // R5
  page_offset_held_chk: assert property (@(posedge clk) disable iff (rst)
    pageValid |=> (!pageValid || $stable(pageOff)));
  // R11
  session_close_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !sessOn |=> (!pageValid && (hvBlk == '0)));
endmodule

bind flash_pgm_seq fps_chk #(.NUM_BLK(NUM_BLK), .OFFW(OFFW)) chk_i (.*);

// File: tb/flash_pgm_seq_tb_top.sv
`timescale 1ns/1ps
module flash_pgm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        busSel, busWr, busRegSel;
  logic [16:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic        pgmEn, blk0En;
  logic        arrRdEn, marginRd, pageValid;
  logic [16:0] arrAddr;
  logic [31:0] arrRdData;
  logic [7:0]  pageOff, hvBlk;
  logic [2:0]  pulseSel;
  logic [1:0]  marginCtl;
  logic [2:0]  pgmBlk;
  logic [3:0]  pgmWord;
  logic [31:0] pgmData;
  logic        pgmWordValid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_pgm_seq dut_i (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busRegSel(busRegSel),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pgmEn(pgmEn), .blk0En(blk0En), .arrRdEn(arrRdEn), .arrAddr(arrAddr),
    .arrRdData(arrRdData), .marginRd(marginRd), .pageValid(pageValid),
    .pageOff(pageOff), .pulseSel(pulseSel), .marginCtl(marginCtl),
    .hvBlk(hvBlk), .pgmBlk(pgmBlk), .pgmWord(pgmWord), .pgmData(pgmData),
    .pgmWordValid(pgmWordValid)
  );

  typedef struct packed {
    logic        wr;
    logic        isReg;
    logic [16:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // nominal program flow; reads carry expected values
  localparam vec_t TBL [13] = '{
    '{1'b1, 1'b1, 17'h00000, 32'h0000_0038, 32'h0},          // R4 control-1 setup
    '{1'b0, 1'b1, 17'h00000, 32'h0,         32'h0000_0038},  // R4 readback
    '{1'b1, 1'b1, 17'h00004, 32'h0000_0005, 32'h0},          // R4 mask blocks 0,2
    '{1'b1, 1'b1, 17'h00004, 32'h0000_0205, 32'h0},          // R4 session on
    '{1'b0, 1'b1, 17'h00008, 32'h0,         32'h0},          // R5 nothing latched yet
    '{1'b1, 1'b0, 17'h0048C, 32'hA5A5_0003, 32'h0},          // R5 blk0 off 0x12 word 3
    '{1'b0, 1'b1, 17'h00008, 32'h0,         32'h0000_0020},  // R5 page latched
    '{1'b1, 1'b0, 17'h0848C, 32'h2222_0003, 32'h0},          // R7 blk2 word 3
    '{1'b1, 1'b0, 17'h00C0C, 32'hBEEF_0003, 32'h0},          // R6 blk0 word 3 rewrite, other offset
    '{1'b1, 1'b0, 17'h0448C, 32'h1111_0003, 32'h0},          // R7 blk1 not selected
    '{1'b1, 1'b1, 17'h00004, 32'h0000_0605, 32'h0},          // R4 request
    '{1'b0, 1'b1, 17'h00004, 32'h0,         32'h0000_0605},  // R4 request accepted
    '{1'b0, 1'b1, 17'h00008, 32'h0,         32'h0000_0020}   // R10 no empty block
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic isReg, input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busRegSel = isReg; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic isReg, input logic [16:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busRegSel = isReg; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    rst = 1'b1; busSel = 1'b0; busWr = 1'b0; busRegSel = 1'b0;
    busAddr = '0; busWdata = '0; pgmEn = 1'b1; blk0En = 1'b1;
    arrRdData = 32'hDEAD_0000; pgmBlk = '0; pgmWord = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    busRead(1'b1, 17'h0, rd); chk("R1 ctl1", rd, 32'h1);
    busRead(1'b1, 17'h4, rd); chk("R1 ctl2", rd, 32'h0);
    busRead(1'b1, 17'h8, rd); chk("R1 status", rd, 32'h0);
    chk("R1 hv", 32'(hvBlk), 32'h0);
    chk("R1 page", 32'(pageValid), 32'h0);

    for (int i = 0; i < 13; i++) begin
      if (TBL[i].wr) busWrite(TBL[i].isReg, TBL[i].addr, TBL[i].data);
      else begin
        busRead(TBL[i].isReg, TBL[i].addr, rd);
        chk($sformatf("R4/R5/R10 vector %0d", i), rd, TBL[i].exp);
      end
    end

    @(negedge clk);
    chk("R4 hv mask", 32'(hvBlk), 32'h05);
    chk("R4 pulse", 32'({marginCtl, pulseSel}), 32'h1C);
    chk("R5 offset", 32'(pageOff), 32'h12);
    pgmBlk = 3'd0; pgmWord = 4'd3; #1;
    chk("R6 last write kept", pgmData, 32'hBEEF_0003);
    pgmBlk = 3'd2; #1;
    chk("R7 blk2 data", pgmData, 32'h2222_0003);
    pgmBlk = 3'd1; #1;
    chk("R7 unselected blk1", 32'(pgmWordValid), 32'h0);
    pgmBlk = 3'd0; pgmWord = 4'd2; #1;
    chk("R6 unwritten word", 32'(pgmWordValid), 32'h0);

    // R8 steering and margin reads
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busRegSel = 1'b0; busAddr = 17'h0048C; #1;
    chk("R8 on-page margin", 32'(marginRd), 32'h0);
    chk("R8 on-page addr", 32'(arrAddr), 32'h0048C);
    chk("R8 read data", busRdata, 32'hDEAD_0000);
    busAddr = 17'h0080C; #1;
    chk("R8 off-page margin", 32'(marginRd), 32'h1);
    chk("R8 off-page addr", 32'(arrAddr), 32'h0048C);
    busSel = 1'b0;

    // R3 enable inputs
    @(negedge clk);
    pgmEn = 1'b0; #1;
    chk("R3 global enable", 32'(hvBlk), 32'h0);
    pgmEn = 1'b1; blk0En = 1'b0; #1;
    chk("R3 block0 enable", 32'(hvBlk), 32'h04);
    blk0En = 1'b1;

    // R2 lock with a pending request
    busWrite(1'b1, 17'h0, 32'h39);
    chk("R2 locked", 32'(hvBlk), 32'h0);
    busWrite(1'b1, 17'h0, 32'h38);
    chk("R2 unlocked", 32'(hvBlk), 32'h05);

    // R11 session close
    busWrite(1'b1, 17'h4, 32'h005);
    chk("R11 hv drop", 32'(hvBlk), 32'h0);
    @(negedge clk);
    chk("R11 page clear", 32'(pageValid), 32'h0);
    pgmBlk = 3'd0; pgmWord = 4'd3; #1;
    chk("R11 flags clear", 32'(pgmWordValid), 32'h0);

    // R12 write with session closed
    busWrite(1'b0, 17'h0048C, 32'h7);
    @(negedge clk);
    chk("R12 no latch", 32'(pageValid), 32'h0);
    chk("R12 no flag", 32'(pgmWordValid), 32'h0);

    // R9 request with no session, then with no page
    busWrite(1'b1, 17'h4, 32'h405);
    busRead(1'b1, 17'h8, rd); chk("R9 err no session", rd, 32'h10);
    chk("R9 hv off", 32'(hvBlk), 32'h0);
    busWrite(1'b1, 17'h8, 32'h10);
    busRead(1'b1, 17'h8, rd); chk("R9 err cleared", rd, 32'h0);
    busWrite(1'b1, 17'h4, 32'h205);
    busWrite(1'b1, 17'h4, 32'h605);
    busRead(1'b1, 17'h8, rd); chk("R9 err no page", rd, 32'h10);
    busWrite(1'b1, 17'h8, 32'h10);

    // R9 request and session close in one write
    busWrite(1'b1, 17'h4, 32'h205);
    busWrite(1'b0, 17'h0048C, 32'h9);
    busWrite(1'b1, 17'h4, 32'h405);
    chk("R9 same-cycle hv", 32'(hvBlk), 32'h0);
    busRead(1'b1, 17'h4, rd); chk("R9 same-cycle ctl2", rd, 32'h005);
    busRead(1'b1, 17'h8, rd); chk("R9 same-cycle err", rd & 32'h10, 32'h10);
    busWrite(1'b1, 17'h8, 32'h10);

    // R10 empty count with three selected, one written
    busWrite(1'b1, 17'h4, 32'h007);
    busWrite(1'b1, 17'h4, 32'h207);
    busWrite(1'b0, 17'h04140, 32'h55);
    busWrite(1'b1, 17'h4, 32'h607);
    busRead(1'b1, 17'h8, rd); chk("R10 empty count", rd, 32'h22);
    chk("R10 hv mask", 32'(hvBlk), 32'h07);

    finishRun();
  end
endmodule